// File: doc/BRIEF.md
# Single-bit alias bridge

This bridge sits between a bus master and a backing memory. It makes every bit of a backing region look like a separate word inside a much larger alias window. A read from an alias word returns the one backing bit it stands for, in bit 0. A write to an alias word changes only that bit. The bridge does this with an atomic read-modify-write of the enclosing backing data.

Two alias windows are built in, each 32 MiB long:
- alias addresses 0x2200_0000 to 0x23FF_FFFF map onto backing memory at 0x2000_0000;
- alias addresses 0x4200_0000 to 0x43FF_FFFF map onto backing memory at 0x4000_0000.

The bridge takes one request at a time on its slave side. It issues one or two backing accesses on its master side. It then returns a single-cycle response that carries an error flag.

Top module: `bitband_bridge`

## Requirements
- R1: An alias address inside 0x2200_0000..0x23FF_FFFF maps to backing address 0x2000_0000 | (offset[24:0] >> 5). An alias address inside 0x4200_0000..0x43FF_FFFF maps to 0x4000_0000 | (offset[24:0] >> 5).
- R2: The access size code is s_size_i = 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The backing access uses the same size code, and its address is the mapped address rounded down to a multiple of the size.
- R3: Backing data is right-aligned and little-endian: byte k of an access sits in data bits [8k+7:8k]. The selected bit index within that data is alias address bits [6:2] ANDed with (8 × bytes − 1). As a result, the same absolute backing bit is addressed whatever the access size.
- R4: An alias read issues exactly one backing read. It responds with the selected bit in s_rsp_rdata_o[0], with bits [31:1] at zero and the error flag low.
- R5: An alias write issues a backing read and then a backing write to the same address and size. The written data equals the data read, except that the selected bit is replaced by s_wdata_i[0]. Bits [31:1] of the write data have no effect.
- R6: If the backing read reports an error, the alias response carries the error and no backing write is issued.
- R7: An error reported by the backing write-back is returned on the alias write response.
- R8: A request outside both windows, or with size code 3, gets a response with the error flag set and causes no backing access.
- R9: s_ready_o is low from the cycle after acceptance until the response cycle, inclusive. The response is a one-cycle pulse, and s_ready_o is high again in the next cycle.
- R10: After reset, s_ready_o is high and m_req_o and s_rsp_valid_o are low.
- R11: m_req_o, together with its address, size, direction and write data, stays stable until the cycle in which m_rsp_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_req_i | input | 1 | Alias request valid; accepted when s_ready_o is high |
| s_we_i | input | 1 | Alias request is a write |
| s_addr_i | input | 32 | Alias byte address |
| s_size_i | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| s_wdata_i | input | 32 | Write data; only bit 0 is used |
| s_ready_o | output | 1 | Bridge idle and able to accept a request |
| s_rsp_valid_o | output | 1 | One-cycle response pulse |
| s_rsp_rdata_o | output | 32 | Read result: the selected bit in bit 0 |
| s_rsp_err_o | output | 1 | Response error (decode or backing error) |
| m_req_o | output | 1 | Backing access pending |
| m_we_o | output | 1 | Backing access is a write |
| m_addr_o | output | 32 | Backing byte address, aligned to the size |
| m_size_o | output | 2 | Backing size code |
| m_wdata_o | output | 32 | Backing write data, right-aligned |
| m_rsp_valid_i | input | 1 | Backing access completes this cycle |
| m_rdata_i | input | 32 | Backing read data, right-aligned |
| m_err_i | input | 1 | Backing access error, valid with m_rsp_valid_i |

## Verification
The bench drives random reads and writes across both windows and all three sizes, with random response latencies and random upper write-data bits. It keeps a shadow copy of the region that is indexed only by absolute bit number. This exposes a wrong bit position or size mask, and any disturbance of neighbouring bits.

Directed cases cover several separate failure classes:
- window edges and addresses just outside the windows, which separate decode mistakes from translation mistakes;
- size code 3, which is only a decode error;
- injected read errors, which show a write-back leaking through;
- injected write errors, which show a dropped write-back error.

Checking the backing address and size on each access separates a wrong alignment from a wrong bit selection.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } bb_state_e;

  // byte count of a size code, 0 for the illegal code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/bb_win_decode.sv
module bb_win_decode
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BACK_BASE  = '0,
  localparam int unsigned POS_W    = $clog2(DATA_W),
  localparam int unsigned OFF_SH   = 3 + $clog2(DATA_W / 8)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] back_addr_o,
  output logic [POS_W-1:0]  bit_pos_o
);

  logic [NUM_WIN-1:0]              win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_addr;
  logic [ADDR_W-1:0]               raw_addr;
  logic [2:0]                      nbytes;
  logic [ADDR_W-1:0]               align_mask;
  logic [POS_W-1:0]                pos_mask;
  logic                            unused_lsb;

  assign unused_lsb = ^addr_i[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w]  = addr_i[ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[w][ADDR_W-1:SPAN_LOG2];
    assign win_addr[w] = BACK_BASE[w]
                       | (ADDR_W'(addr_i[SPAN_LOG2-1:0]) >> OFF_SH);
  end

  always_comb begin
    raw_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_hit[w]) raw_addr = raw_addr | win_addr[w];
    end
  end

  assign nbytes      = size_bytes(size_i);
  assign align_mask  = ~(ADDR_W'(nbytes) - ADDR_W'(1));
  assign pos_mask    = POS_W'({nbytes, 3'b000} - 6'd1);
  assign ok_o        = (|win_hit) && (nbytes != 3'd0);
  assign back_addr_o = raw_addr & align_mask;
  assign bit_pos_o   = addr_i[POS_W+1:2] & pos_mask;

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
  import bb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W),
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic [1:0]        size_i,
  input  logic              wbit_i,
  output logic              rbit_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [2:0]        nbytes;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] merged;

  assign nbytes = size_bytes(size_i);

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = (b < int'(nbytes)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    merged            = rdata_i;
    merged[bit_pos_i] = wbit_i;
  end

  assign rbit_o  = rdata_i[bit_pos_i];
  assign wdata_o = merged & lane_mask;

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  input  logic              s_we_i,
  input  logic              s_wbit_i,
  input  logic              dec_ok_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic [POS_W-1:0]  dec_pos_i,
  input  logic [1:0]        dec_size_i,
  output logic              s_ready_o,
  output logic              s_rsp_valid_o,
  output logic              s_rsp_err_o,
  output logic              s_rsp_rbit_o,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [1:0]        m_size_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic              m_rsp_valid_i,
  input  logic              m_err_i,
  input  logic              lane_rbit_i,
  input  logic [DATA_W-1:0] lane_wdata_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [1:0]        size_o,
  output logic              wbit_o
);

  bb_state_e         state_q;
  logic              we_q, wbit_q, err_q, rbit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [POS_W-1:0]  pos_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      wbit_q  <= 1'b0;
      err_q   <= 1'b0;
      rbit_q  <= 1'b0;
      addr_q  <= '0;
      pos_q   <= '0;
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (s_req_i) begin
          we_q    <= s_we_i;
          wbit_q  <= s_wbit_i;
          addr_q  <= dec_addr_i;
          pos_q   <= dec_pos_i;
          size_q  <= dec_size_i;
          err_q   <= !dec_ok_i;
          rbit_q  <= 1'b0;
          state_q <= dec_ok_i ? ST_READ : ST_RESP;
        end
        ST_READ: if (m_rsp_valid_i) begin
          if (m_err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else if (we_q) begin
            wdata_q <= lane_wdata_i;
            state_q <= ST_WRITE;
          end else begin
            rbit_q  <= lane_rbit_i;
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: if (m_rsp_valid_i) begin
          err_q   <= m_err_i;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ready_o     = state_q == ST_IDLE;
  assign s_rsp_valid_o = state_q == ST_RESP;
  assign s_rsp_err_o   = s_rsp_valid_o & err_q;
  assign s_rsp_rbit_o  = s_rsp_valid_o & rbit_q;
  assign m_req_o       = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign m_we_o        = state_q == ST_WRITE;
  assign m_addr_o      = addr_q;
  assign m_size_o      = size_q;
  assign m_wdata_o     = wdata_q;
  assign pos_o         = pos_q;
  assign size_o        = size_q;
  assign wbit_o        = wbit_q;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BACK_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  input  logic              s_we_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [1:0]        s_size_i,
  input  logic [DATA_W-1:0] s_wdata_i,
  output logic              s_ready_o,
  output logic              s_rsp_valid_o,
  output logic [DATA_W-1:0] s_rsp_rdata_o,
  output logic              s_rsp_err_o,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [1:0]        m_size_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic              m_rsp_valid_i,
  input  logic [DATA_W-1:0] m_rdata_i,
  input  logic              m_err_i
);

  localparam int unsigned POS_W = $clog2(DATA_W);

  logic              dec_ok;
  logic [ADDR_W-1:0] dec_addr;
  logic [POS_W-1:0]  dec_pos;
  logic [POS_W-1:0]  cur_pos;
  logic [1:0]        cur_size;
  logic              cur_wbit;
  logic              lane_rbit;
  logic [DATA_W-1:0] lane_wdata;
  logic              rsp_rbit;
  logic              unused_wdata;

  assign unused_wdata = ^s_wdata_i[DATA_W-1:1];

  bb_win_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_WIN   (NUM_WIN),
    .SPAN_LOG2 (SPAN_LOG2),
    .ALIAS_BASE(ALIAS_BASE),
    .BACK_BASE (BACK_BASE)
  ) u_dec (
    .addr_i     (s_addr_i),
    .size_i     (s_size_i),
    .ok_o       (dec_ok),
    .back_addr_o(dec_addr),
    .bit_pos_o  (dec_pos)
  );

  bb_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .s_req_i      (s_req_i),
    .s_we_i       (s_we_i),
    .s_wbit_i     (s_wdata_i[0]),
    .dec_ok_i     (dec_ok),
    .dec_addr_i   (dec_addr),
    .dec_pos_i    (dec_pos),
    .dec_size_i   (s_size_i),
    .s_ready_o    (s_ready_o),
    .s_rsp_valid_o(s_rsp_valid_o),
    .s_rsp_err_o  (s_rsp_err_o),
    .s_rsp_rbit_o (rsp_rbit),
    .m_req_o      (m_req_o),
    .m_we_o       (m_we_o),
    .m_addr_o     (m_addr_o),
    .m_size_o     (m_size_o),
    .m_wdata_o    (m_wdata_o),
    .m_rsp_valid_i(m_rsp_valid_i),
    .m_err_i      (m_err_i),
    .lane_rbit_i  (lane_rbit),
    .lane_wdata_i (lane_wdata),
    .pos_o        (cur_pos),
    .size_o       (cur_size),
    .wbit_o       (cur_wbit)
  );

  bb_bit_lane #(
    .DATA_W(DATA_W)
  ) u_lane (
    .rdata_i  (m_rdata_i),
    .bit_pos_i(cur_pos),
    .size_i   (cur_size),
    .wbit_i   (cur_wbit),
    .rbit_o   (lane_rbit),
    .wdata_o  (lane_wdata)
  );

  assign s_rsp_rdata_o = {{(DATA_W-1){1'b0}}, rsp_rbit};

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_req_i,
  input logic              s_ready_o,
  input logic              s_rsp_valid_o,
  input logic [DATA_W-1:0] s_rsp_rdata_o,
  input logic              m_req_o,
  input logic              m_we_o,
  input logic [ADDR_W-1:0] m_addr_o,
  input logic [1:0]        m_size_o,
  input logic [DATA_W-1:0] m_wdata_o,
  input logic              m_rsp_valid_i
);

  // R9: no new acceptance while a backing access is pending
  a_r9_busy_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> !s_ready_o);

  // R9: response is a single-cycle pulse followed by ready
  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rsp_valid_o |=> !s_rsp_valid_o && s_ready_o);

  // R9: acceptance leads to a busy bridge
  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_req_i && s_ready_o |=> !s_ready_o);

  // R4: only bit 0 of read data may be set
  a_r4_rdata_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rsp_valid_o |-> s_rsp_rdata_o[DATA_W-1:1] == '0);

  // R2: backing address aligned to size
  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> ((m_size_o == 2'd1) -> !m_addr_o[0]) && ((m_size_o == 2'd2) -> m_addr_o[1:0] == 2'b00));

  // R8: illegal size never reaches the backing side
  a_r8_no_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> m_size_o != 2'd3);

  // R11: pending request held stable until its response
  a_r11_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && !m_rsp_valid_i |=> m_req_o && $stable(m_addr_o) && $stable(m_size_o)
                                  && $stable(m_we_o) && $stable(m_wdata_o));

  // R5: write-back directly follows the completed read of the same address
  a_r5_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && m_we_o && $rose(m_we_o) |-> $past(m_req_o) && $past(m_rsp_valid_i) && $stable(m_addr_o));

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .s_req_i      (s_req_i),
  .s_ready_o    (s_ready_o),
  .s_rsp_valid_o(s_rsp_valid_o),
  .s_rsp_rdata_o(s_rsp_rdata_o),
  .m_req_o      (m_req_o),
  .m_we_o       (m_we_o),
  .m_addr_o     (m_addr_o),
  .m_size_o     (m_size_o),
  .m_wdata_o    (m_wdata_o),
  .m_rsp_valid_i(m_rsp_valid_i)
);

// File: tb/bitband_bridge_test.sv
`timescale 1ns/1ps
module bitband_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_req = 1'b0, s_we = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic [1:0]  s_size = '0;
  logic        s_ready, s_rsp_valid, s_rsp_err;
  logic [31:0] s_rsp_rdata;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic        m_rsp_valid = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitband_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_req_i(s_req), .s_we_i(s_we), .s_addr_i(s_addr), .s_size_i(s_size), .s_wdata_i(s_wdata),
    .s_ready_o(s_ready), .s_rsp_valid_o(s_rsp_valid), .s_rsp_rdata_o(s_rsp_rdata), .s_rsp_err_o(s_rsp_err),
    .m_req_o(m_req), .m_we_o(m_we), .m_addr_o(m_addr), .m_size_o(m_size), .m_wdata_o(m_wdata),
    .m_rsp_valid_i(m_rsp_valid), .m_rdata_i(m_rdata), .m_err_i(m_err)
  );

  // backing memory model and shadow (indexed by window, low 10 address bits)
  logic [7:0] mem [2][1024];
  logic [7:0] shd [2][1024];
  int  rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [1:0]  last_rd_size, last_wr_size;
  bit  inj_rd_err = 0, inj_wr_err = 0;

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && m_req && !m_rsp_valid) begin
        logic        we;
        logic [31:0] a, wd;
        logic [1:0]  sz;
        bit          er;
        int          w;
        we = m_we; a = m_addr; sz = m_size; wd = m_wdata;
        w = int'(a[30]);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (we) begin
          wr_cnt++; last_wr_addr = a; last_wr_size = sz; er = inj_wr_err;
        end else begin
          rd_cnt++; last_rd_addr = a; last_rd_size = sz; er = inj_rd_err;
        end
        m_rdata = $urandom;
        if (!we)
          for (int k = 0; k < nb(sz); k++) m_rdata[8*k +: 8] = mem[w][(int'(a[9:0]) + k) & 1023];
        m_err = er;
        m_rsp_valid = 1'b1;
        @(negedge clk);
        m_rsp_valid = 1'b0;
        m_err = 1'b0;
        if (we && !er)
          for (int k = 0; k < nb(sz); k++) mem[w][(int'(a[9:0]) + k) & 1023] = wd[8*k +: 8];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  bit hs_bad;

  task automatic access(input bit we, input logic [31:0] addr, input logic [1:0] sz, input bit wbit,
                        output logic [31:0] rd, output bit er);
    int n;
    hs_bad = 0;
    @(negedge clk);
    if (!s_ready) hs_bad = 1;
    s_req = 1; s_we = we; s_addr = addr; s_size = sz;
    s_wdata = {$urandom(), 1'b0} | 32'(wbit);
    @(negedge clk);
    s_req = 0;
    n = 0;
    while (!s_rsp_valid && n < 100) begin
      if (s_ready) hs_bad = 1;
      @(negedge clk); n++;
    end
    rd = s_rsp_rdata; er = s_rsp_err;
    if (s_ready) hs_bad = 1;
    @(negedge clk);
    if (!s_ready || s_rsp_valid) hs_bad = 1;
    check(!hs_bad && n < 100, "R9 handshake", 32'(hs_bad), 32'd0);
  endtask

  function automatic logic [31:0] shd_word(input int w, input int byte_i);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = shd[w][((byte_i & ~3) + k) & 1023];
    return v;
  endfunction

  function automatic logic [31:0] mem_word(input int w, input int byte_i);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = mem[w][((byte_i & ~3) + k) & 1023];
    return v;
  endfunction

  // full alias access with independent expectation
  task automatic alias_op(input bit we, input int w, input logic [24:0] off, input logic [1:0] sz, input bit wbit);
    logic [31:0] addr, rd, exp_a;
    bit er;
    int rc, wc, byte_i, bit_i;
    addr   = (w != 0 ? 32'h4200_0000 : 32'h2200_0000) | 32'(off);
    byte_i = int'(off >> 5);
    bit_i  = int'(off[4:2]);
    exp_a  = (w != 0 ? 32'h4000_0000 : 32'h2000_0000) | (32'(byte_i) & ~32'(nb(sz) - 1));
    rc = rd_cnt; wc = wr_cnt;
    access(we, addr, sz, wbit, rd, er);
    check(!er, "R1 no error in window", 32'(er), 32'd0);
    check(rd_cnt == rc + 1 && last_rd_addr == exp_a && last_rd_size == sz,
          "R2 backing read address/size", last_rd_addr, exp_a);
    if (we) begin
      shd[w][byte_i & 1023][bit_i] = wbit;
      check(wr_cnt == wc + 1 && last_wr_addr == exp_a && last_wr_size == sz,
            "R5 write-back address/size", last_wr_addr, exp_a);
      check(mem_word(w, byte_i) == shd_word(w, byte_i), "R5 R3 backing bits after write",
            mem_word(w, byte_i), shd_word(w, byte_i));
    end else begin
      check(wr_cnt == wc, "R4 no write on read", 32'(wr_cnt - wc), 32'd0);
      check(rd == 32'(shd[w][byte_i & 1023][bit_i]), "R4 R3 read bit",
            rd, 32'(shd[w][byte_i & 1023][bit_i]));
    end
  endtask

  task automatic bad_op(input logic [31:0] addr, input logic [1:0] sz, input bit we);
    logic [31:0] rd;
    bit er;
    int rc, wc;
    rc = rd_cnt; wc = wr_cnt;
    access(we, addr, sz, 1'b1, rd, er);
    check(er, "R8 decode error flag", 32'(er), 32'd1);
    check(rd_cnt == rc && wr_cnt == wc, "R8 no backing access", 32'(rd_cnt - rc + wr_cnt - wc), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    bit er;
    int rc, wc;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 1024; i++) begin
        mem[w][i] = 8'($urandom);
        shd[w][i] = mem[w][i];
      end
    repeat (3) @(negedge clk);
    check(s_ready && !m_req && !s_rsp_valid, "R10 reset state",
          {29'd0, s_ready, m_req, s_rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready && !m_req && !s_rsp_valid, "R10 after reset release",
          {29'd0, s_ready, m_req, s_rsp_valid}, 32'h4);

    // directed: window edges, all sizes
    alias_op(1, 0, 25'h0, 2'd0, 1'b1);
    alias_op(0, 0, 25'h0, 2'd2, 1'b0);
    alias_op(1, 1, 25'h1FF_FFFC, 2'd2, 1'b0);
    alias_op(0, 1, 25'h1FF_FFFC, 2'd0, 1'b0);
    alias_op(1, 0, 25'h0_003C, 2'd1, 1'b1);   // bit 15 of halfword: R3
    alias_op(0, 0, 25'h0_003C, 2'd0, 1'b0);
    alias_op(1, 1, 25'h0_007F, 2'd2, 1'b0);   // low address bits ignored
    alias_op(0, 1, 25'h0_007C, 2'd1, 1'b0);

    // decode errors: R8
    bad_op(32'h2400_0000, 2'd2, 1'b0);
    bad_op(32'h21FF_FFFC, 2'd0, 1'b1);
    bad_op(32'h0000_0000, 2'd1, 1'b0);
    bad_op(32'h4400_0000, 2'd0, 1'b1);
    bad_op(32'h2200_0010, 2'd3, 1'b0);
    bad_op(32'h4200_0010, 2'd3, 1'b1);

    // R6: read error, no write-back, memory untouched
    inj_rd_err = 1;
    rc = rd_cnt; wc = wr_cnt;
    access(1, 32'h2200_0100, 2'd2, 1'b1, rd, er);
    check(er, "R6 read error returned", 32'(er), 32'd1);
    check(rd_cnt == rc + 1 && wr_cnt == wc, "R6 no write-back", 32'(wr_cnt - wc), 32'd0);
    check(mem_word(0, 8) == shd_word(0, 8), "R6 memory unchanged", mem_word(0, 8), shd_word(0, 8));
    access(0, 32'h4200_0100, 2'd0, 1'b0, rd, er);
    check(er, "R6 read error on alias read", 32'(er), 32'd1);
    inj_rd_err = 0;

    // R7: write-back error
    inj_wr_err = 1;
    rc = rd_cnt; wc = wr_cnt;
    access(1, 32'h4200_0200, 2'd1, 1'b1, rd, er);
    check(er, "R7 write error returned", 32'(er), 32'd1);
    check(rd_cnt == rc + 1 && wr_cnt == wc + 1, "R7 one read one write", 32'(wr_cnt - wc), 32'd1);
    inj_wr_err = 0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [24:0] off;
      logic [1:0]  sz;
      off = 25'($urandom_range(0, 32767));
      sz  = 2'($urandom_range(0, 2));
      alias_op(1'($urandom), int'($urandom_range(0, 1)), off, sz, 1'($urandom));
    end

    finish_run();
  end

endmodule